// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Controller

This block produces up to eight pulse-width-modulated outputs from one clock. Software programs each channel through a small word-addressed register bus. Every channel has a timing register and a phase-window register. The timing register sets the period length, the pin level inside and outside the window, and a per-channel clock divider. The phase-window register sets where the window opens and closes. One shared register holds an enable bit per channel.

Every register can be reached at four addresses. One address writes it directly, and the other three set, clear or toggle bits. A controller can therefore change a single channel's enable without a read-modify-write.

Register writes land in staging registers first. While a channel runs, the values that drive the pin are copied from staging only when the counter wraps at the end of a period, and only after the timing register has been written. Software writes the window register first and the timing register last. The new pair then takes effect together at a period boundary, with no partial period on the pin.

Top module: `shadow_pwm`

## Requirements
- R1: After reset every register reads 0 and every output is 0.
- R2: The enable register is at byte address 0x00, where bit n enables channel n. Channel n's window register is at 0x10+0x20*n and its timing register is at 0x20+0x20*n. Timing register bits 31:23 read as zero. A write whose address bits 1:0 are not zero is ignored. A read at any of the four addresses of a register returns that register.
- R3: Address offsets +0x0, +0x4, +0x8 and +0xC from a register's base respectively write the data, OR it in, clear the bits written as one, and XOR it in. This holds for every register.
- R4: A running channel's counter advances once per divided tick. It returns to 0 on the tick after it equals the period field (timing bits 15:0), so a period lasts period+1 ticks. The count restarts at 0 when the channel is enabled.
- R5: The divider code in timing bits 22:20 selects a tick every 1, 2, 4, 8, 16, 64, 256 or 1024 clocks for codes 0 to 7.
- R6: While the channel runs, the pin takes the window level when start <= count < stop, and the idle level otherwise. Start is window bits 15:0 and stop is window bits 31:16.
- R7: Timing bits 17:16 give the window level and bits 19:18 give the idle level. Code 2'b11 drives the pin high; 2'b10 and every other code drive it low.
- R8: While a channel runs, writes to its registers leave the pin unchanged until the first period boundary after a timing-register write. A window-register write alone stays pending across boundaries.
- R9: A timing-register write that lands on the clock edge that ends a period does not take effect at that boundary. The staged pair takes effect at the following boundary.
- R10: A disabled channel holds its count at 0 and drives its idle level. That level comes from the staged timing register, one clock after the register is written. Enabling the channel uses the latest staged values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_o | output | NCH | Channel pin outputs |

## Verification
Two functions can meet on one clock edge: a timing-register write and the counter wrap that ends a period. The bench places the write exactly on the edge where the count returns to 0, with a window change already staged. It then samples the pin on the cycles after that edge. If the change is applied one period early, a mismatch shows up at count 1. A second case leaves a window-only write pending across a boundary. Each pin sample is compared with a value the bench computes from the elapsed cycle count, the divider ratio and the staged fields.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;
   localparam int PERIOD_W  = 16;
   localparam int MAX_SHIFT = 10;
   localparam int PER_BITS  = 23;

   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_TOGGLE = 2'd3
   } alias_op_e;

   typedef struct packed {
      logic [PERIOD_W-1:0] stop_cnt;
      logic [PERIOD_W-1:0] start_cnt;
   } win_cfg_t;

   typedef struct packed {
      logic [2:0]          div_code;
      logic [1:0]          idle_lvl;
      logic [1:0]          win_lvl;
      logic [PERIOD_W-1:0] period;
   } tim_cfg_t;

   // Divider exponent: linear up to 4, then steps of two.
   function automatic int shift_of_code(input logic [2:0] code);
      return (code < 3'd5) ? int'(code) : 2 * int'(code) - 4;
   endfunction

   function automatic logic lvl_drive(input logic [1:0] lvl);
      return lvl == 2'b11;
   endfunction
endpackage

// File: rtl/spwm_alias.sv
`timescale 1ns/1ps
module spwm_alias
   import spwm_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] wd,
   input  alias_op_e    op,
   output logic [W-1:0] nxt
);
   if (W < 1) begin : g_bad_w
      $error("spwm_alias: W must be positive");
   end

   always_comb begin
      case (op)
         OP_SET:    nxt = cur | wd;
         OP_CLEAR:  nxt = cur & ~wd;
         OP_TOGGLE: nxt = cur ^ wd;
         default:   nxt = wd;
      endcase
   end
endmodule

// File: rtl/spwm_regs.sv
`timescale 1ns/1ps
module spwm_regs
   import spwm_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    ch_en,
   output win_cfg_t          win_cfg [NCH],
   output tim_cfg_t          tim_cfg [NCH],
   output logic [NCH-1:0]    tim_wr
);
   localparam int IDX_W = ADDR_W - 4;

   logic [IDX_W-1:0] idx;
   alias_op_e        op;
   logic             wr_ok;
   logic [NCH-1:0]   ctrl_q, ctrl_nxt;
   logic [31:0]      win_rd [NCH];
   logic [PER_BITS-1:0] tim_rd [NCH];

   assign idx   = bus_addr[ADDR_W-1:4];
   assign op    = alias_op_e'(bus_addr[3:2]);
   assign wr_ok = bus_wr && (bus_addr[1:0] == 2'b00);

   spwm_alias #(.W(NCH)) u_ctrl_alias (
      .cur(ctrl_q), .wd(bus_wdata[NCH-1:0]), .op(op), .nxt(ctrl_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl_q <= '0;
      else if (wr_ok && idx == IDX_W'(0))  ctrl_q <= ctrl_nxt;
   end
   assign ch_en = ctrl_q;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam logic [IDX_W-1:0] WIN_IDX = IDX_W'(2 * n + 1);
      localparam logic [IDX_W-1:0] TIM_IDX = IDX_W'(2 * n + 2);

      win_cfg_t            win_r;
      logic [PER_BITS-1:0] tim_r, tim_nxt;
      logic [31:0]         win_nxt;
      logic                win_hit, tim_hit;

      assign win_hit = wr_ok && (idx == WIN_IDX);
      assign tim_hit = wr_ok && (idx == TIM_IDX);

      spwm_alias #(.W(32)) u_win_alias (
         .cur(win_r), .wd(bus_wdata), .op(op), .nxt(win_nxt)
      );
      spwm_alias #(.W(PER_BITS)) u_tim_alias (
         .cur(tim_r), .wd(bus_wdata[PER_BITS-1:0]), .op(op), .nxt(tim_nxt)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_r <= '0;
            tim_r <= '0;
         end else begin
            if (win_hit) win_r <= win_nxt;
            if (tim_hit) tim_r <= tim_nxt;
         end
      end

      assign win_cfg[n] = win_r;
      assign tim_cfg[n] = tim_cfg_t'(tim_r);
      assign tim_wr[n]  = tim_hit;
      assign win_rd[n]  = win_r;
      assign tim_rd[n]  = tim_r;
   end

   always_comb begin
      bus_rdata = '0;
      if (idx == IDX_W'(0)) bus_rdata[NCH-1:0] = ctrl_q;
      for (int k = 0; k < NCH; k++) begin
         if (idx == IDX_W'(2 * k + 1)) bus_rdata = win_rd[k];
         if (idx == IDX_W'(2 * k + 2)) bus_rdata = {{(32 - PER_BITS){1'b0}}, tim_rd[k]};
      end
   end

   // R3: set alias leaves every written-one bit set
   assert_ctrl_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && idx == IDX_W'(0) && op == OP_SET)
      |=> ((ctrl_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

   // R3: clear alias leaves every written-one bit clear
   assert_ctrl_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && idx == IDX_W'(0) && op == OP_CLEAR)
      |=> ((ctrl_q & $past(bus_wdata[NCH-1:0])) == '0));
endmodule

// File: rtl/spwm_prescale.sv
`timescale 1ns/1ps
module spwm_prescale
   import spwm_pkg::*;
#(
   parameter int DIV_W = MAX_SHIFT
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] div_code,
   output logic       tick
);
   if (DIV_W < MAX_SHIFT) begin : g_bad_div
      $error("spwm_prescale: DIV_W too small for the largest ratio");
   end

   logic [DIV_W-1:0] div_q, lim;

   assign lim  = DIV_W'((32'd1 << shift_of_code(div_code)) - 32'd1);
   assign tick = run && (div_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            div_q <= '0;
      else if (!run || tick) div_q <= '0;
      else                   div_q <= div_q + 1'b1;
   end

   // R5: every tick restarts the divider
   assert_tick_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (div_q == '0));
endmodule

// File: rtl/spwm_channel.sv
`timescale 1ns/1ps
module spwm_channel
   import spwm_pkg::*;
#(
   parameter bit OUT_REG = 1'b0,
   parameter int DIV_W   = MAX_SHIFT
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  win_cfg_t win_stg,
   input  tim_cfg_t tim_stg,
   input  logic     tim_wr,
   output logic     pwm
);
   win_cfg_t            sh_win;
   tim_cfg_t            sh_tim;
   logic [PERIOD_W-1:0] cnt_q;
   logic                arm_q, tick, wrap, in_win, lvl;

   spwm_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(en),
      .div_code(sh_tim.div_code), .tick(tick)
   );

   assign wrap = tick && (cnt_q == sh_tim.period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!en)   cnt_q <= '0;
      else if (wrap)  cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end

   // A timing write arms the load; the boundary or idling consumes it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            arm_q <= 1'b0;
      else if (tim_wr)       arm_q <= 1'b1;
      else if (!en || wrap)  arm_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_win <= '0;
         sh_tim <= '0;
      end else if (!en || (wrap && arm_q)) begin
         sh_win <= win_stg;
         sh_tim <= tim_stg;
      end
   end

   assign in_win = en && (cnt_q >= sh_win.start_cnt) && (cnt_q < sh_win.stop_cnt);
   assign lvl    = in_win ? lvl_drive(sh_tim.win_lvl) : lvl_drive(sh_tim.idle_lvl);

   if (OUT_REG) begin : g_out_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm <= 1'b0;
         else        pwm <= lvl;
      end
   end else begin : g_out_comb
      assign pwm = lvl;
   end

   // R10: an idle channel sits at count zero
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));

   // R4: the count never passes the applied period
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= sh_tim.period);

   // R8: applied settings change only at a wrap while running
   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wrap) |=> ($stable(sh_win) && $stable(sh_tim)));
endmodule

// File: rtl/shadow_pwm.sv
`timescale 1ns/1ps
module shadow_pwm
   import spwm_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int ADDR_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    pwm_o
);
   localparam int MAP_BYTES = (2 * NCH + 1) * 16;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("shadow_pwm: NCH must be 1 to 8");
   end
   if (ADDR_W < $clog2(MAP_BYTES) || ADDR_W < 5) begin : g_bad_addr
      $error("shadow_pwm: ADDR_W too narrow for the register map");
   end

   logic [NCH-1:0] ch_en, tim_wr;
   win_cfg_t       win_cfg [NCH];
   tim_cfg_t       tim_cfg [NCH];

   spwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .ch_en(ch_en), .win_cfg(win_cfg), .tim_cfg(tim_cfg), .tim_wr(tim_wr)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_chan
      spwm_channel #(.OUT_REG(OUT_REG)) u_chan (
         .clk(clk), .rst_n(rst_n), .en(ch_en[n]),
         .win_stg(win_cfg[n]), .tim_stg(tim_cfg[n]), .tim_wr(tim_wr[n]),
         .pwm(pwm_o[n])
      );
   end
endmodule

// File: tb/shadow_pwm_tb.sv
`timescale 1ns/1ps
module shadow_pwm_tb;
   localparam int NCH    = 4;
   localparam int ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    pwm_o;

   int n_chk = 0;
   int n_err = 0;
   int j = 0;
   bit done = 1'b0;
   int ratio [8] = '{1, 2, 4, 8, 16, 64, 256, 1024};

   always #2 clk = ~clk;

   shadow_pwm #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h (j=%0d)", tag, got, exp, j);
      end
   endtask

   task automatic step();
      @(negedge clk);
      j++;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_addr  = ADDR_W'(a);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      j++;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = ADDR_W'(a);
      #1;
      d = bus_rdata;
   endtask

   function automatic int win_a(input int n); return 16 + 32 * n; endfunction
   function automatic int tim_a(input int n); return 32 + 32 * n; endfunction

   function automatic logic [31:0] tim_word(input int code, input int il, input int wl, input int p);
      return (32'(code) << 20) | (32'(il) << 18) | (32'(wl) << 16) | 32'(p);
   endfunction

   function automatic logic exp_pin(input int k, input int div, input int p,
                                    input int s, input int e, input int wl, input int il);
      int c;
      c = (k / div) % (p + 1);
      return (c >= s && c < e) ? (wl == 3) : (il == 3);
   endfunction

   // Reprogram a channel while idle, then enable it and follow two periods.
   task automatic run_cfg(input int ch, input int code, input int p, input int s,
                          input int e, input int wl, input int il);
      int div;
      div = ratio[code];
      wr(32'h8, 32'(1) << ch);
      wr(win_a(ch), {16'(e), 16'(s)});
      wr(tim_a(ch), tim_word(code, il, wl, p));
      step();
      step();
      check("R10 idle level", 32'(pwm_o[ch]), 32'(il == 3));
      wr(32'h4, 32'(1) << ch);
      j = 0;
      for (int k = 0; k < 2 * div * (p + 1); k++) begin
         check("R4 R5 R6 R7 waveform", 32'(pwm_o[ch]), 32'(exp_pin(k, div, p, s, e, wl, il)));
         step();
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < (2 * NCH + 1) * 16; a += 16) begin
         rd(a, v);
         check("R1 reset register", v, 32'h0);
      end
      check("R1 reset outputs", 32'(pwm_o), 32'h0);

      // R2 / R3: address map and aliases
      wr(win_a(2), 32'h1234_5678);
      rd(win_a(2), v);       check("R2 window write", v, 32'h1234_5678);
      wr(win_a(2) + 4, 32'h0000_8001);
      rd(win_a(2), v);       check("R3 set alias", v, 32'h1234_D679);
      wr(win_a(2) + 8, 32'h0000_0070);
      rd(win_a(2), v);       check("R3 clear alias", v, 32'h1234_D609);
      wr(win_a(2) + 12, 32'hFFFF_0000);
      rd(win_a(2) + 4, v);   check("R2 R3 toggle alias, alias read", v, 32'hEDCB_D609);
      wr(win_a(2) + 1, 32'h0);
      rd(win_a(2), v);       check("R2 misaligned write ignored", v, 32'hEDCB_D609);
      wr(tim_a(3), 32'hFFFF_FFFF);
      rd(tim_a(3), v);       check("R2 timing reserved bits", v, 32'h007F_FFFF);
      wr(tim_a(3) + 12, 32'h0070_0000);
      rd(tim_a(3) + 8, v);   check("R3 timing toggle", v, 32'h000F_FFFF);
      rd(win_a(1), v);       check("R2 neighbour untouched", v, 32'h0);
      wr(32'h0, 32'hFF);
      rd(32'h0, v);          check("R2 enable width", v, 32'hF);
      wr(32'hC, 32'h5);
      rd(32'hC, v);          check("R3 enable toggle", v, 32'hA);
      wr(32'h8, 32'hF);
      rd(32'h0, v);          check("R3 enable clear", v, 32'h0);
      wr(tim_a(3), 32'h0);

      // R4 R5 R6 R7 R10: near-exhaustive sweep of small settings
      for (int code = 0; code < 3; code++) begin
         for (int pi = 0; pi < 2; pi++) begin
            for (int wi = 0; wi < 4; wi++) begin
               for (int li = 0; li < 3; li++) begin
                  int p, s, e, wl, il;
                  p  = (pi == 0) ? 3 : 5;
                  s  = (wi == 1) ? 1 : ((wi == 3) ? 2 : 0);
                  e  = (wi == 0) ? 2 : ((wi == 1) ? p : ((wi == 2) ? p + 1 : 2));
                  wl = (li == 1) ? 2 : ((li == 2) ? 1 : 3);
                  il = (li == 0) ? 2 : 3;
                  run_cfg(0, code, p, s, e, wl, il);
               end
            end
         end
      end

      // R5: large divider ratios
      for (int code = 3; code < 8; code++) run_cfg(2, code, 1, 0, 1, 3, 2);

      // R8: shadowed update on channel 1 (period 7, window 0..3, normal levels)
      wr(32'h8, 32'h2);
      wr(win_a(1), {16'd4, 16'd0});
      wr(tim_a(1), tim_word(0, 2, 3, 7));
      step();
      wr(32'h4, 32'h2);
      j = 0;
      while (j < 16) begin
         check("R8 old settings hold", 32'(pwm_o[1]), 32'((j % 8) < 4));
         if (j == 2)       wr(win_a(1), {16'd2, 16'd0});
         else if (j == 13) wr(tim_a(1), tim_word(0, 2, 3, 3));
         else              step();
      end
      while (j < 32) begin
         check("R8 R9 applied at boundary", 32'(pwm_o[1]), 32'(((j - 16) % 4) < 2));
         if (j == 26)      wr(win_a(1), {16'd1, 16'd0});
         else if (j == 27) wr(tim_a(1), tim_word(0, 2, 3, 5));
         else              step();
      end
      while (j < 44) begin
         check("R9 deferred one period", 32'(pwm_o[1]), 32'(((j - 32) % 6) < 1));
         step();
      end

      // R10: disabling returns the pin to the idle level and holds it
      wr(tim_a(1), tim_word(0, 3, 2, 5));
      wr(32'h8, 32'h2);
      step();
      for (int k = 0; k < 6; k++) begin
         check("R10 disabled holds idle", 32'(pwm_o[1]), 32'h1);
         step();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule